// File: doc/BRIEF.md
# Cascadable Serial LED Channel Register

This block is the digital control path of a sixteen-channel LED sink driver. A bit stream arrives on a serial data pin and a slow shift clock moves it into a sixteen-stage shift register. The oldest stage leaves the block on a serial output, so several drivers can be chained with one data line and one shift clock. A level-sensitive hold register sits between the shift register and the channel outputs. An active-low blanking input turns every channel off without touching the stored pattern.

All control inputs are asynchronous to the fast system clock. They pass through a two-flop synchronizer. A shift happens on each detected rising edge of the synchronized shift clock, and the serial data is sampled alongside it. The system clock must run at least four times faster than the shift clock. A synchronous active-low reset stands in for the power-on reset. It clears both registers and starts the synchronized load input at hold and the synchronized blanking input at "all off", which are the values an undriven pin would take.

Top module: `led_sink_ctrl`

## Requirements
- R1: Each rising edge of `shift_clk` moves the shift register up one stage and loads the current `ser_in` value into stage 0.
- R2: `ser_out` shows stage 15, that is, the bit that entered sixteen shift edges earlier.
- R3: While `load_lvl` is high, the hold register follows the shift register continuously, including shifts made while it stays high.
- R4: While `load_lvl` is low, the hold register keeps its value, and shifting does not change `chan_on`.
- R5: With `blank_n` low, `chan_on[n]` equals hold bit n, and hold bit n was captured from shift stage n. Stage 0 holds the most recent bit, so a word sent most-significant bit first lands with bit n on channel n.
- R6: With `blank_n` high, `chan_on` is all zero. The held pattern is kept and reappears once `blank_n` returns low.
- R7: Reset clears the shift register and the hold register, so `chan_on` and `ser_out` are 0 afterwards. A load that follows without any shifting leaves `chan_on` at 0.
- R8: Operation is correct when `shift_clk` stays high for two system clocks and low for two system clocks, which is the fastest rate allowed (a 4:1 clock ratio).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset (power-on) |
| ser_in | input | 1 | Serial data input, asynchronous |
| shift_clk | input | 1 | Shift clock, asynchronous; rising edge shifts |
| load_lvl | input | 1 | Hold register transparent when high, holds when low |
| blank_n | input | 1 | Active-low enable; high forces all channels off |
| ser_out | output | 1 | Cascade output, shift stage 15 |
| chan_on | output | CHANNELS | Channel-on vector, bit n drives channel n |

## Verification
The bench goes after bit order: a design that reversed the stage-to-channel mapping, or that shifted the wrong way, would show a mirrored pattern on `chan_on` and the wrong bit on `ser_out` during a cascade. It sends several shifts with the load input held high. A hold stage built as an edge-triggered capture would then show only the first snapshot, not the later shifts. It also shifts with the load input low and blanks the channels. A hold that leaked, or a blanking that wiped the stored data, would leave a wrong pattern once blanking is removed. Finally, it runs the shift clock at the 4:1 limit and resets in the middle of a run. A missed or doubled edge, or a register that reset failed to clear, would show up in the next loaded pattern.

// File: rtl/led_pkg.sv
// Shared constants for the LED channel register: control bus layout
// and the reset values that model undriven control pins.
package led_pkg;
    localparam int CTRL_W    = 4;
    localparam int IDX_DATA  = 0;
    localparam int IDX_SHIFT = 1;
    localparam int IDX_LOAD  = 2;
    localparam int IDX_BLANK = 3;
    // Reset value: data 0, shift 0, load low (hold), blank high (off)
    localparam logic [CTRL_W-1:0] CTRL_RST = 4'b1000;
endpackage

// File: rtl/led_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous inputs.
// Assumes each bit is independently meaningful or held stable long
// enough (several clocks) that bundle skew is irrelevant.
module led_sync #(
    parameter int          W       = 4,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // Move the inputs through the flop chain; reset loads pin defaults
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/led_shift.sv
// Serial-in shift register advanced by a one-cycle step strobe.
// Stage 0 takes the new bit; the top stage is the cascade output.
module led_shift #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         din,
    output logic [N-1:0] q
);
    // Shift up one stage on each step strobe
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (step) q <= {q[N-2:0], din};
    end
endmodule

// File: rtl/led_hold.sv
// Level-transparent hold register plus blanking gate and output flops.
// Assumes load and en are already synchronous to clk.
module led_hold #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         en,
    input  logic [N-1:0] d,
    output logic [N-1:0] chan
);
    logic [N-1:0] held;

    // Follow the shift register while load is high, keep it otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)    held <= '0;
        else if (load) held <= d;
    end

    // Registered channel outputs, forced off when not enabled
    always_ff @(posedge clk) begin
        if (!rst_n) chan <= '0;
        else        chan <= en ? held : '0;
    end
endmodule

// File: rtl/led_sink_ctrl.sv
// Control path of a cascadable LED sink driver. It synchronizes the
// serial pins, detects shift clock rising edges, shifts data, holds it
// in a level-sensitive register and gates the channels with an
// active-low blanking input. Assumes clk >= 4x the shift clock rate.
module led_sink_ctrl
    import led_pkg::*;
#(
    parameter int CHANNELS    = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ser_in,
    input  logic                shift_clk,
    input  logic                load_lvl,
    input  logic                blank_n,
    output logic                ser_out,
    output logic [CHANNELS-1:0] chan_on
);
    logic [CTRL_W-1:0]   ctrl_raw;
    logic [CTRL_W-1:0]   ctrl_s;
    logic                shift_prev;
    logic                step;
    logic [CHANNELS-1:0] stages;

    always_comb begin
        ctrl_raw            = '0;
        ctrl_raw[IDX_DATA]  = ser_in;
        ctrl_raw[IDX_SHIFT] = shift_clk;
        ctrl_raw[IDX_LOAD]  = load_lvl;
        ctrl_raw[IDX_BLANK] = blank_n;
    end

    led_sync #(
        .W(CTRL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTRL_RST)
    ) sync_i (
        .clk(clk), .rst_n(rst_n), .d(ctrl_raw), .q(ctrl_s)
    );

    // Remember the previous synchronized shift clock for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) shift_prev <= 1'b0;
        else        shift_prev <= ctrl_s[IDX_SHIFT];
    end

    assign step = ctrl_s[IDX_SHIFT] & ~shift_prev;

    led_shift #(.N(CHANNELS)) shift_i (
        .clk(clk), .rst_n(rst_n), .step(step),
        .din(ctrl_s[IDX_DATA]), .q(stages)
    );

    led_hold #(.N(CHANNELS)) hold_i (
        .clk(clk), .rst_n(rst_n), .load(ctrl_s[IDX_LOAD]),
        .en(~ctrl_s[IDX_BLANK]), .d(stages), .chan(chan_on)
    );

    assign ser_out = stages[CHANNELS-1];
endmodule

// File: rtl/led_sink_ctrl_chk.sv
// Port-level temporal checks for led_sink_ctrl, bound to every instance.
// Windows cover the synchronizer and output register latency.
module led_sink_ctrl_chk #(
    parameter int CHANNELS = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                shift_clk,
    input logic                load_lvl,
    input logic                blank_n,
    input logic                ser_out,
    input logic [CHANNELS-1:0] chan_on
);
    // R7
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (chan_on == '0) && !ser_out);

    // R6
    blank_forces_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n,5) && $past(blank_n,2) && $past(blank_n,3) &&
         $past(blank_n,4) && $past(blank_n,5)) |-> (chan_on == '0));

    // R2
    serout_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n,6) && !shift_clk && !$past(shift_clk,1) && !$past(shift_clk,2) &&
         !$past(shift_clk,3) && !$past(shift_clk,4) && !$past(shift_clk,5))
        |-> $stable(ser_out));

    // R4
    hold_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n,6) && !$past(load_lvl,1) && !$past(load_lvl,2) && !$past(load_lvl,3) &&
         !$past(load_lvl,4) && !$past(load_lvl,5) && !$past(load_lvl,6) &&
         !$past(blank_n,1) && !$past(blank_n,2) && !$past(blank_n,3) &&
         !$past(blank_n,4) && !$past(blank_n,5) && !$past(blank_n,6))
        |-> $stable(chan_on));
endmodule

bind led_sink_ctrl led_sink_ctrl_chk #(.CHANNELS(CHANNELS)) chk_i (
    .clk(clk), .rst_n(rst_n), .shift_clk(shift_clk), .load_lvl(load_lvl),
    .blank_n(blank_n), .ser_out(ser_out), .chan_on(chan_on)
);

// File: tb/led_sink_ctrl_tb_top.sv
module led_sink_ctrl_tb_top;
    localparam int N = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ser_in = 1'b0;
    logic         shift_clk = 1'b0;
    logic         load_lvl = 1'b0;
    logic         blank_n = 1'b1;
    logic         ser_out;
    logic [N-1:0] chan_on;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic [N-1:0] m_sr  = '0;
    logic [N-1:0] m_lat = '0;

    always #4 clk = ~clk;

    led_sink_ctrl #(.CHANNELS(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .shift_clk(shift_clk),
        .load_lvl(load_lvl), .blank_n(blank_n), .ser_out(ser_out), .chan_on(chan_on)
    );

    function automatic logic [N-1:0] exp_chan(logic [N-1:0] lat, logic blank);
        return blank ? '0 : lat;
    endfunction

    task automatic check(string tag, logic [N-1:0] act, logic [N-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    // One shift clock pulse carrying bit b, half period in system clocks
    task automatic shift_bit(logic b, int half);
        shift_clk = 1'b0; ser_in = b;
        wait_cyc(half);
        shift_clk = 1'b1;
        wait_cyc(half);
        m_sr = {m_sr[N-2:0], b};
        if (load_lvl) m_lat = m_sr;
    endtask

    task automatic settle();
        shift_clk = 1'b0;
        wait_cyc(8);
    endtask

    task automatic shift_word(logic [N-1:0] w, int half);
        for (int i = N-1; i >= 0; i--) shift_bit(w[i], half);
        settle();
    endtask

    task automatic pulse_load();
        load_lvl = 1'b1; wait_cyc(6);
        load_lvl = 1'b0; wait_cyc(6);
        m_lat = m_sr;
    endtask

    task automatic check_outputs(string tag);
        check({tag, " chan_on"}, chan_on, exp_chan(m_lat, blank_n));
        check({tag, " ser_out"}, {{(N-1){1'b0}}, ser_out}, {{(N-1){1'b0}}, m_sr[N-1]});
    endtask

    initial begin
        process::self().srandom(32'd7341);
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(3);
        check_outputs("R7 after reset");

        // R1 R5: MSB-first word lands bit n on channel n
        shift_word(16'hA5C3, 4);
        pulse_load();
        blank_n = 1'b0; wait_cyc(6);
        check("R5 pattern", chan_on, 16'hA5C3);
        check("R2 ser_out stage15", {15'd0, ser_out}, 16'd1);

        // R2: during the next word, ser_out walks the old word
        shift_bit(1'b0, 4); settle();
        check("R2 cascade bit14", {15'd0, ser_out}, {15'd0, 1'b0});
        shift_bit(1'b1, 4); settle();
        check("R2 cascade bit13", {15'd0, ser_out}, {15'd0, 1'b1});
        // R4: shifting with load low leaves channels unchanged
        shift_word(16'h1234, 4);
        check("R4 hold", chan_on, 16'hA5C3);
        check_outputs("R4");

        // R6: blank off and back on keeps data
        blank_n = 1'b1; wait_cyc(6);
        check("R6 blanked", chan_on, '0);
        blank_n = 1'b0; wait_cyc(6);
        check("R6 restored", chan_on, 16'hA5C3);

        // R3: transparent while load is high
        load_lvl = 1'b1; wait_cyc(6);
        m_lat = m_sr;
        check_outputs("R3 open");
        for (int k = 0; k < 5; k++) begin
            shift_bit(k[0], 3); settle();
            check_outputs("R3 follow");
        end
        load_lvl = 1'b0; wait_cyc(6);

        // R8: fastest shift rate
        shift_word(16'h6E19, 2);
        pulse_load();
        check("R8 fast pattern", chan_on, 16'h6E19);
        check_outputs("R8");

        // Random mix (R1 R2 R5 R6 R8)
        for (int it = 0; it < 30; it++) begin
            logic [N-1:0] w;
            int half;
            w = N'($urandom);
            half = 2 + int'($urandom_range(0, 2));
            shift_word(w, half);
            if ($urandom_range(0, 1) == 1) pulse_load();
            blank_n = logic'($urandom_range(0, 1));
            wait_cyc(6);
            check_outputs("R1 random");
        end

        // R7: reset in mid-run clears both registers
        blank_n = 1'b0;
        rst_n = 1'b0; wait_cyc(3); rst_n = 1'b1; wait_cyc(4);
        m_sr = '0; m_lat = '0;
        blank_n = 1'b0; wait_cyc(6);
        check_outputs("R7 mid reset");
        pulse_load();
        check("R7 load after reset", chan_on, '0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule